// File: doc/BRIEF.md
# DMA Transfer Phase Sequencer

This block is the per-transfer engine of a DMA controller on a segmented peripheral interconnect. Once an upstream arbiter hands it a channel number, it reads that channel's descriptor from a small descriptor memory. It then reads 16-bit beats from the source segment and writes them to the destination segment. Last, it writes the advanced descriptor back to the same memory location and raises a one-cycle completion pulse. Each data side has its own request/available handshake. A request is held until the segment reports it is free, and a beat moves on a clock edge where request and available are both high.

One pass moves at most 16 bytes, which is the size of the internal staging FIFO. When both ends sit on the same segment, the whole pass is read into the FIFO before the first destination write. When they are on different segments, reads and writes alternate one beat at a time. A longer transfer is handled as repeated grants: each pass writes back the remaining byte count.

Top module: `dma_phase_seq`

## Requirements
- R1: After reset, busy, done, descRd, descWr, srcReq and dstReq are all low.
- R2: A grant seen while idle causes descRd to be asserted one cycle later, with descAddr equal to the granted channel. The descriptor word is laid out as [45:43] source segment, [42:40] destination segment, [39:24] source address, [23:8] destination address, [7:0] byte count.
- R3: While srcReq is high and srcAvail is low, srcReq, srcSeg and srcAddr hold their values. Source beat k of a pass is read at the descriptor's source address plus 2k, on the descriptor's source segment.
- R4: Destination beat k of a pass is written at the descriptor's destination address plus 2k, on the descriptor's destination segment.
- R5: When the source and destination segments are equal, every source beat of the pass completes before the first destination beat.
- R6: When the segments differ, the beats strictly alternate, source then destination. srcReq and dstReq are never high together.
- R7: The destination beats carry the source beats' data in the same order.
- R8: A pass moves min(count, 16) bytes as ceil(bytes/2) beats.
- R9: Write-back stores, to the granted channel's address, the same segments, both addresses advanced by 2 per beat, and the count reduced by the pass size.
- R10: done is high for exactly the one cycle after the write-back cycle. busy is low the cycle after that.
- R11: A descriptor with count 0 makes no segment request and writes back its fields unchanged.
- R12: A grant that arrives while busy is ignored. The other channel's descriptor is neither read nor written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| grantValid | input | 1 | Channel granted this cycle |
| grantChan | input | CH_W | Granted channel number |
| busy | output | 1 | Sequencer is handling a transfer |
| descRd | output | 1 | Descriptor read strobe (data returns next cycle) |
| descWr | output | 1 | Descriptor write-back strobe |
| descAddr | output | CH_W | Descriptor memory address (channel) |
| descWData | output | 46 | Descriptor write-back word |
| descRData | input | 46 | Descriptor read word |
| srcReq | output | 1 | Source segment read request |
| srcSeg | output | 3 | Source segment select |
| srcAddr | output | 16 | Source peripheral address |
| srcAvail | input | 1 | Source segment free this cycle |
| srcData | input | 16 | Source read data |
| dstReq | output | 1 | Destination segment write request |
| dstSeg | output | 3 | Destination segment select |
| dstAddr | output | 16 | Destination peripheral address |
| dstAvail | input | 1 | Destination segment free this cycle |
| dstData | output | 16 | Destination write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
Segment availability is random, so some handshakes wait many cycles. A design that let its request or address move during a wait would lose beats or fetch the wrong address. Same-segment and different-segment passes are both exercised, and a wrong mode choice appears as a mismatch in the order of the handshakes. Directed cases cover counts of 0, 1, 16 and 17. A design that computed the pass size or the odd-byte rounding wrongly would show the wrong beat count or a wrong written-back count and addresses. A grant arriving mid-transfer is also tested, and a design that accepted it would issue a stray descriptor read.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  parameter int SEG_W  = 3;
  parameter int ADDR_W = 16;
  parameter int CNT_W  = 8;
  parameter int BEAT_W = 16;
  localparam int DESC_W = 2 * SEG_W + 2 * ADDR_W + CNT_W;

  typedef struct packed {
    logic [SEG_W-1:0]  srcSeg;
    logic [SEG_W-1:0]  dstSeg;
    logic [ADDR_W-1:0] srcAddr;
    logic [ADDR_W-1:0] dstAddr;
    logic [CNT_W-1:0]  count;
  } descT;

  typedef struct packed {
    logic loadDesc;
    logic pushBeat;
    logic popBeat;
  } strobeT;

  typedef struct packed {
    logic sameSeg;
    logic emptyDesc;
    logic rdLast;
    logic wrLast;
  } statT;

  typedef enum logic [2:0] {
    PH_IDLE, PH_FETCH, PH_LOAD, PH_SRC, PH_DST, PH_WB, PH_DONE
  } phaseT;
endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            grantValid,
  input  logic [CH_W-1:0] grantChan,
  input  statT            stat,
  input  logic            srcAvail,
  input  logic            dstAvail,
  output strobeT          strobe,
  output logic            busy,
  output logic            descRd,
  output logic            descWr,
  output logic [CH_W-1:0] descAddr,
  output logic            srcReq,
  output logic            dstReq,
  output logic            done
);
  phaseT phase, phaseNext;
  logic [CH_W-1:0] chanR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      chanR <= '0;
    end else begin
      phase <= phaseNext;
      if (phase == PH_IDLE && grantValid) chanR <= grantChan;
    end
  end

  always_comb begin
    phaseNext = phase;
    strobe    = '0;
    case (phase)
      PH_IDLE:  if (grantValid) phaseNext = PH_FETCH;
      PH_FETCH: phaseNext = PH_LOAD;
      PH_LOAD: begin
        strobe.loadDesc = 1'b1;
        phaseNext = stat.emptyDesc ? PH_WB : PH_SRC;
      end
      PH_SRC: if (srcAvail) begin
        strobe.pushBeat = 1'b1;
        if (!stat.sameSeg || stat.rdLast) phaseNext = PH_DST;
      end
      PH_DST: if (dstAvail) begin
        strobe.popBeat = 1'b1;
        if (stat.wrLast)        phaseNext = PH_WB;
        else if (!stat.sameSeg) phaseNext = PH_SRC;
      end
      PH_WB:   phaseNext = PH_DONE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  assign busy     = (phase != PH_IDLE);
  assign descRd   = (phase == PH_FETCH);
  assign descWr   = (phase == PH_WB);
  assign descAddr = chanR;
  assign srcReq   = (phase == PH_SRC);
  assign dstReq   = (phase == PH_DST);
  assign done     = (phase == PH_DONE);

  p_one_side_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(srcReq && dstReq));
  p_same_seg_order_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dstReq && stat.sameSeg) |=> !srcReq);
  p_done_after_wb_r10: assert property (@(posedge clk) disable iff (!rstN)
    descWr |=> done);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);
  p_src_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    (srcReq && !srcAvail) |=> srcReq);
endmodule

// File: rtl/dma_seq_dpath.sv
module dma_seq_dpath
  import dma_seq_pkg::*;
#(
  parameter int FIFO_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [DESC_W-1:0] descRData,
  input  logic [BEAT_W-1:0] srcData,
  output statT              stat,
  output logic [DESC_W-1:0] descWData,
  output logic [SEG_W-1:0]  srcSeg,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [SEG_W-1:0]  dstSeg,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [BEAT_W-1:0] dstData
);
  localparam int BEAT_BYTES = BEAT_W / 8;
  localparam int DEPTH      = FIFO_BYTES / BEAT_BYTES;
  localparam int PTR_W      = $clog2(DEPTH);
  localparam int FILL_W     = PTR_W + 1;
  localparam logic [CNT_W-1:0]  PASS_MAX = CNT_W'(FIFO_BYTES);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(BEAT_BYTES);

  descT inDesc;
  assign inDesc = descRData;

  logic [SEG_W-1:0]  srcSegR, dstSegR;
  logic [ADDR_W-1:0] srcAddrR, dstAddrR;
  logic [CNT_W-1:0]  countR, passR;
  logic [FILL_W-1:0] rdLeft, wrLeft, fill;
  logic [PTR_W-1:0]  wPtr, rPtr;
  logic [BEAT_W-1:0] fifoMem [DEPTH];

  logic [CNT_W-1:0]  passIn;
  logic [CNT_W:0]    beatsIn;
  assign passIn  = (inDesc.count > PASS_MAX) ? PASS_MAX : inDesc.count;
  assign beatsIn = ({1'b0, passIn} + (CNT_W+1)'(BEAT_BYTES - 1)) / (CNT_W+1)'(BEAT_BYTES);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSegR <= '0; dstSegR <= '0; srcAddrR <= '0; dstAddrR <= '0;
      countR <= '0; passR <= '0; rdLeft <= '0; wrLeft <= '0;
      fill <= '0; wPtr <= '0; rPtr <= '0;
    end else begin
      if (strobe.loadDesc) begin
        srcSegR  <= inDesc.srcSeg;
        dstSegR  <= inDesc.dstSeg;
        srcAddrR <= inDesc.srcAddr;
        dstAddrR <= inDesc.dstAddr;
        countR   <= inDesc.count;
        passR    <= passIn;
        rdLeft   <= FILL_W'(beatsIn);
        wrLeft   <= FILL_W'(beatsIn);
        fill     <= '0;
        wPtr     <= '0;
        rPtr     <= '0;
      end else begin
        if (strobe.pushBeat) begin
          wPtr     <= wPtr + 1'b1;
          srcAddrR <= srcAddrR + STEP;
          rdLeft   <= rdLeft - 1'b1;
        end
        if (strobe.popBeat) begin
          rPtr     <= rPtr + 1'b1;
          dstAddrR <= dstAddrR + STEP;
          wrLeft   <= wrLeft - 1'b1;
        end
        case ({strobe.pushBeat, strobe.popBeat})
          2'b10:   fill <= fill + 1'b1;
          2'b01:   fill <= fill - 1'b1;
          default: fill <= fill;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.pushBeat) fifoMem[wPtr] <= srcData;
  end

  assign stat.sameSeg   = (srcSegR == dstSegR);
  assign stat.emptyDesc = (inDesc.count == '0);
  assign stat.rdLast    = (rdLeft == FILL_W'(1));
  assign stat.wrLast    = (wrLeft == FILL_W'(1));

  descT wbDesc;
  always_comb begin
    wbDesc.srcSeg  = srcSegR;
    wbDesc.dstSeg  = dstSegR;
    wbDesc.srcAddr = srcAddrR;
    wbDesc.dstAddr = dstAddrR;
    wbDesc.count   = countR - passR;
  end
  assign descWData = wbDesc;
  assign srcSeg    = srcSegR;
  assign srcAddr   = srcAddrR;
  assign dstSeg    = dstSegR;
  assign dstAddr   = dstAddrR;
  assign dstData   = fifoMem[rPtr];

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushBeat |-> (fill < FILL_W'(DEPTH)));
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popBeat |-> (fill != '0));
  p_src_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pushBeat && !strobe.loadDesc) |=> (srcAddrR == $past(srcAddrR) + STEP));
endmodule

// File: rtl/dma_phase_seq.sv
module dma_phase_seq
  import dma_seq_pkg::*;
#(
  parameter int CH_W       = 3,
  parameter int FIFO_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              grantValid,
  input  logic [CH_W-1:0]   grantChan,
  output logic              busy,
  output logic              descRd,
  output logic              descWr,
  output logic [CH_W-1:0]   descAddr,
  output logic [DESC_W-1:0] descWData,
  input  logic [DESC_W-1:0] descRData,
  output logic              srcReq,
  output logic [SEG_W-1:0]  srcSeg,
  output logic [ADDR_W-1:0] srcAddr,
  input  logic              srcAvail,
  input  logic [BEAT_W-1:0] srcData,
  output logic              dstReq,
  output logic [SEG_W-1:0]  dstSeg,
  output logic [ADDR_W-1:0] dstAddr,
  input  logic              dstAvail,
  output logic [BEAT_W-1:0] dstData,
  output logic              done
);
  strobeT strobe;
  statT   stat;

  dma_seq_ctrl #(.CH_W(CH_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .grantValid(grantValid), .grantChan(grantChan),
    .stat(stat), .srcAvail(srcAvail), .dstAvail(dstAvail), .strobe(strobe),
    .busy(busy), .descRd(descRd), .descWr(descWr), .descAddr(descAddr),
    .srcReq(srcReq), .dstReq(dstReq), .done(done)
  );

  dma_seq_dpath #(.FIFO_BYTES(FIFO_BYTES)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .descRData(descRData),
    .srcData(srcData), .stat(stat), .descWData(descWData),
    .srcSeg(srcSeg), .srcAddr(srcAddr), .dstSeg(dstSeg), .dstAddr(dstAddr),
    .dstData(dstData)
  );

  p_src_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (srcReq && !srcAvail) |=> ($stable(srcAddr) && $stable(srcSeg)));
  p_dst_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dstReq && !dstAvail) |=> (dstReq && $stable(dstAddr) && $stable(dstData)));
  p_grant_fetch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && grantValid) |=> (descRd && descAddr == $past(grantChan)));
endmodule

// File: tb/dma_phase_seq_bench.sv
module dma_phase_seq_bench;
  localparam int CH_W = 3;
  localparam int DW   = 46;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic grantValid = 1'b0;
  logic [CH_W-1:0] grantChan = '0;
  logic busy, descRd, descWr, srcReq, dstReq, done;
  logic [CH_W-1:0] descAddr;
  logic [DW-1:0] descWData;
  logic [DW-1:0] descRData;
  logic [2:0] srcSeg, dstSeg;
  logic [15:0] srcAddr, dstAddr, srcData, dstData;
  logic srcAvail = 1'b0, dstAvail = 1'b0;

  always #2 clk = ~clk;

  dma_phase_seq u_dma_phase_seq (
    .clk(clk), .rstN(rstN), .grantValid(grantValid), .grantChan(grantChan),
    .busy(busy), .descRd(descRd), .descWr(descWr), .descAddr(descAddr),
    .descWData(descWData), .descRData(descRData),
    .srcReq(srcReq), .srcSeg(srcSeg), .srcAddr(srcAddr), .srcAvail(srcAvail),
    .srcData(srcData), .dstReq(dstReq), .dstSeg(dstSeg), .dstAddr(dstAddr),
    .dstAvail(dstAvail), .dstData(dstData), .done(done)
  );

  int nTests = 0, nFail = 0;
  logic [DW-1:0] mem [8];

  always @(posedge clk) begin
    if (descRd) descRData <= mem[descAddr];
    if (descWr) mem[descAddr] <= descWData;
  end

  function automatic logic [15:0] srcModel(logic [2:0] s, logic [15:0] a);
    return {a[12:0], s} ^ 16'h5A3C;
  endfunction
  assign srcData = srcModel(srcSeg, srcAddr);

  // handshake log filled at each negedge
  int evN = 0;
  int availPct = 50;
  int expChan = 0;
  int strayRd = 0;
  logic wbSeen = 1'b0;
  logic [DW-1:0] wbWord;
  logic [CH_W-1:0] wbAddr;
  logic evType [64];
  logic [15:0] evAddr [64];
  logic [15:0] evData [64];
  logic [2:0]  evSeg [64];
  logic prevWait = 1'b0;
  logic [15:0] prevAddr;
  logic [2:0] prevSeg;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (prevWait) begin
        check("R3 hold", {srcReq, srcSeg, srcAddr}, {1'b1, prevSeg, prevAddr});
      end
      srcAvail = ($urandom_range(99) < availPct);
      dstAvail = ($urandom_range(99) < availPct);
      prevWait = srcReq && !srcAvail;
      prevAddr = srcAddr;
      prevSeg  = srcSeg;
      if (srcReq && srcAvail && evN < 64) begin
        evType[evN] = 1'b0; evAddr[evN] = srcAddr; evData[evN] = srcData; evSeg[evN] = srcSeg;
        evN++;
      end
      if (dstReq && dstAvail && evN < 64) begin
        evType[evN] = 1'b1; evAddr[evN] = dstAddr; evData[evN] = dstData; evSeg[evN] = dstSeg;
        evN++;
      end
      if (descWr) begin
        wbSeen = 1'b1; wbWord = descWData; wbAddr = descAddr;
      end
      if (descRd && descAddr != CH_W'(expChan)) strayRd++;
    end
  end

  task automatic runXfer(int ch, logic [2:0] sS, logic [2:0] dS, logic [15:0] sA,
                         logic [15:0] dA, logic [7:0] cnt, int pct, bit intrude);
    int pass, beats, guard;
    logic [DW-1:0] other;
    logic [15:0] rdData [8];
    int nRd, nWr;
    pass  = (cnt > 16) ? 16 : int'(cnt);
    beats = (pass + 1) / 2;
    mem[ch] = {sS, dS, sA, dA, cnt};
    other = mem[ch ^ 1];
    availPct = pct; expChan = ch; strayRd = 0;
    @(negedge clk); #1;
    check("R10 idle before grant", {63'd0, busy}, 64'd0);
    evN = 0; wbSeen = 1'b0;
    grantValid = 1'b1; grantChan = CH_W'(ch);
    @(negedge clk); #1;
    grantValid = 1'b0;
    check("R2 fetch", {descRd, descAddr}, {1'b1, CH_W'(ch)});
    guard = 0;
    while (!wbSeen && guard < 3000) begin
      if (intrude && guard == 3) begin grantValid = 1'b1; grantChan = CH_W'(ch ^ 1); end
      if (intrude && guard == 6) grantValid = 1'b0;
      @(negedge clk); #1;
      guard++;
    end
    grantValid = 1'b0;
    if (!wbSeen) begin
      nTests++; nFail++;
      $display("FAIL R10 watchdog actual=no-writeback expected=writeback");
      return;
    end
    @(negedge clk); #1;
    check("R10 done high", {63'd0, done}, 64'd1);
    @(negedge clk); #1;
    check("R10 done low busy low", {62'd0, done, busy}, 64'd0);
    check("R8 beat count", 64'(evN), 64'(2 * beats));
    nRd = 0; nWr = 0;
    for (int k = 0; k < evN && k < 2 * beats; k++) begin
      logic expT;
      expT = (sS == dS) ? (k >= beats) : (k % 2 == 1);
      if (sS == dS) check("R5 order", {63'd0, evType[k]}, {63'd0, expT});
      else          check("R6 order", {63'd0, evType[k]}, {63'd0, expT});
      if (!evType[k]) begin
        check("R3 src addr", {evSeg[k], evAddr[k]}, {sS, sA + 16'(2 * nRd)});
        if (nRd < 8) rdData[nRd] = evData[k];
        nRd++;
      end else begin
        check("R4 dst addr", {evSeg[k], evAddr[k]}, {dS, dA + 16'(2 * nWr)});
        if (nWr < 8 && nWr < nRd) check("R7 data", 64'(evData[k]), 64'(rdData[nWr]));
        nWr++;
      end
    end
    if (cnt == 0) check("R11 no beats", 64'(evN), 64'd0);
    check("R9 writeback", {wbAddr, wbWord},
          {CH_W'(ch), sS, dS, sA + 16'(2 * beats), dA + 16'(2 * beats), cnt - 8'(pass)});
    if (intrude) begin
      check("R12 stray read", 64'(strayRd), 64'd0);
      check("R12 other channel", 64'(mem[ch ^ 1]), 64'(other));
      repeat (3) @(negedge clk);
      #1;
      check("R12 stays idle", {63'd0, busy}, 64'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd7741));
    for (int i = 0; i < 8; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset", {58'd0, busy, done, descRd, descWr, srcReq, dstReq}, 64'd0);
    rstN = 1'b1;
    // directed corners
    runXfer(2, 3'd4, 3'd4, 16'h1000, 16'h2000, 8'd16, 40, 1'b0);
    runXfer(5, 3'd1, 3'd6, 16'h0100, 16'h0800, 8'd17, 30, 1'b0);
    runXfer(3, 3'd2, 3'd2, 16'h0040, 16'h0060, 8'd1, 60, 1'b0);
    runXfer(0, 3'd7, 3'd0, 16'hFFF0, 16'h3000, 8'd0, 50, 1'b0);
    runXfer(6, 3'd5, 3'd5, 16'h0200, 16'h0400, 8'd12, 20, 1'b1);
    runXfer(1, 3'd3, 3'd0, 16'h0A00, 16'h0B00, 8'd9, 25, 1'b1);
    // constrained random
    for (int t = 0; t < 40; t++) begin
      logic [2:0] s, d;
      s = 3'($urandom_range(7));
      d = ($urandom_range(1) == 0) ? s : 3'($urandom_range(7));
      runXfer(int'($urandom_range(7)), s, d, 16'($urandom) & 16'hFFFE,
              16'($urandom) & 16'hFFFE, 8'($urandom_range(40)),
              int'($urandom_range(15, 95)), 1'b0);
    end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #400000;
    nTests++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule